// File: doc/BRIEF.md
# Scanned BCD Seven-Segment Display Driver with Leading-Zero Suppression

This block drives a multi-digit seven-segment display through one shared decoder. It shows the digits one at a time and takes them from a packed BCD word, starting with the most significant digit. For the digit on show it drives active-high segment lines and a one-hot digit select. Each digit stays on for a fixed number of clock cycles, set by a parameter. Segment, select and ripple outputs are registered and change only at a slot boundary, so the lit digit never shows a transient pattern.

Leading zeros are suppressed by carrying a ripple-blanking flag forward in time. At every slot boundary the decoder's ripple output is stored in a flip-flop. That flag becomes the ripple input of the next, less significant digit. The flag is cleared at the start of each frame. The least significant digit always sees it set, so a value of zero still shows one 0.

A lamp-test request lights every segment of every digit. Dropping the enable line blanks the whole display.

Top module: `bcd_scan_display`

## Requirements
- R1: While synchronous reset `rst` is high, and after it falls until the first slot boundary, `segOut`, `digitSel` and `rboOut` are all 0. The first boundary comes DWELL_CYCLES clock edges after reset is released, and the first digit shown is the most significant one.
- R2: `digitSel` has at most one bit set. Digit i occupies `bcdWord[4i+3:4i]` and is lit on `digitSel[i]`. The scan goes from i = NUM_DIGITS-1 down to 0 and then wraps. Every slot lasts exactly DWELL_CYCLES cycles, and the outputs hold steady inside a slot.
- R3: With enable 1 and lamp test 0, codes 1 to 9 are always shown and `rboOut` is 1. `segOut` bit 6 is segment a and bit 0 is segment g. The patterns are: 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=0011111, 7=1110000, 8=1111111, 9=1110011.
- R4: With enable 1 and lamp test 0, codes 10 to 15 give `segOut` = 0000000 and `rboOut` = 1. A following zero is then displayed.
- R5: With enable 1 and lamp test 0, a code of 0 whose incoming ripple flag is 0 is blanked and gives `rboOut` = 0. The most significant digit always receives a ripple flag of 0.
- R6: With enable 1 and lamp test 0, a code of 0 whose incoming ripple flag is 1 shows 1111110 and gives `rboOut` = 1. A zero that follows a significant digit is therefore shown.
- R7: The least significant digit always receives a ripple flag of 1, so an all-zero word shows a single 0 in digit 0.
- R8: While `lampTest` is 1, every digit shows 1111111 with `rboOut` = 0, whatever the values of `enable` and `bcdWord`.
- R9: While `enable` is 0 and `lampTest` is 0, every digit shows 0000000 with `rboOut` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bcdWord | input | 4*NUM_DIGITS | Packed BCD value; digit i in bits 4i+3:4i |
| enable | input | 1 | Display enable; 0 blanks all digits |
| lampTest | input | 1 | Lamp-test request; lights all segments |
| segOut | output | 7 | Segments a..g, a in bit 6, active high |
| digitSel | output | NUM_DIGITS | One-hot select of the lit digit |
| rboOut | output | 1 | Ripple-blanking output of the lit digit |

## Verification
The bench builds the block with NUM_DIGITS = 4 and DWELL_CYCLES = 3. A complete frame therefore takes 12 cycles, so many whole frames fit in a short run. Four digits are enough to reach a blanked leading run, a zero buried between significant digits, an invalid code in the middle of the word, and the forced ripple flag on the last digit. The short dwell also lets the bench sample each slot just after it starts and again just before it ends. This shows that outputs move only at the boundaries, and it lets the bench confirm that a reset in mid-scan restarts at the top digit.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef struct packed {
    logic load;
    logic firstSlot;
    logic lastSlot;
  } slot_strobe_t;

  localparam logic [6:0] SEG_ALL  = 7'b1111111;
  localparam logic [6:0] SEG_OFF  = 7'b0000000;
  localparam logic [6:0] SEG_ZERO = 7'b1111110;

  // a in bit 6 .. g in bit 0
  function automatic logic [6:0] fontOf(input logic [3:0] code);
    logic [6:0] pat;
    case (code)
      4'd0:    pat = SEG_ZERO;
      4'd1:    pat = 7'b0110000;
      4'd2:    pat = 7'b1101101;
      4'd3:    pat = 7'b1111001;
      4'd4:    pat = 7'b0110011;
      4'd5:    pat = 7'b1011011;
      4'd6:    pat = 7'b0011111;
      4'd7:    pat = 7'b1110000;
      4'd8:    pat = 7'b1111111;
      4'd9:    pat = 7'b1110011;
      default: pat = SEG_OFF;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS   = 6,
  parameter int DWELL_CYCLES = 50000,
  localparam int IDX_W  = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int TICK_W = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] slotIdx,
  output slot_strobe_t     strobes
);

  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_DIGITS - 1);
  localparam logic [TICK_W-1:0] TICK_MAX = TICK_W'(DWELL_CYCLES - 1);

  logic [TICK_W-1:0] tick;
  logic [IDX_W-1:0]  pendIdx;
  logic              boundary;

  assign boundary = (tick == TICK_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= '0;
      pendIdx <= LAST_IDX;
    end else if (boundary) begin
      tick    <= '0;
      pendIdx <= (pendIdx == '0) ? LAST_IDX : pendIdx - 1'b1;
    end else begin
      tick    <= tick + 1'b1;
    end
  end

  assign slotIdx           = pendIdx;
  assign strobes.load      = boundary;
  assign strobes.firstSlot = (pendIdx == LAST_IDX);
  assign strobes.lastSlot  = (pendIdx == '0);

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    pendIdx <= LAST_IDX);

  // R2
  wrap_to_msd_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load && strobes.lastSlot |=> strobes.firstSlot);

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(pendIdx));

endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import scan_pkg::*;
(
  input  logic       en,
  input  logic       rbi,
  input  logic [3:0] code,
  output logic [6:0] seg,
  output logic       rbo
);

  always_comb begin
    if (!en && !rbi) begin
      seg = SEG_ALL;
      rbo = 1'b0;
    end else if (!en) begin
      seg = SEG_OFF;
      rbo = 1'b1;
    end else if (code == 4'd0) begin
      seg = rbi ? SEG_ZERO : SEG_OFF;
      rbo = rbi;
    end else begin
      seg = fontOf(code);
      rbo = 1'b1;
    end
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS = 6,
  localparam int IDX_W  = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int WORD_W = 4 * NUM_DIGITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORD_W-1:0]     bcdWord,
  input  logic                  enable,
  input  logic                  lampTest,
  input  logic [IDX_W-1:0]      slotIdx,
  input  slot_strobe_t          strobes,
  output logic [6:0]            segOut,
  output logic [NUM_DIGITS-1:0] digitSel,
  output logic                  rboOut
);

  logic [3:0]            digit;
  logic [NUM_DIGITS-1:0] nextSel;
  logic                  rippleFf;
  logic                  chainIn;
  logic                  decEn;
  logic                  decRbi;
  logic [6:0]            decSeg;
  logic                  decRbo;
  logic [6:0]            segReg;
  logic [NUM_DIGITS-1:0] selReg;
  logic                  rboReg;

  always_comb begin
    digit   = 4'd0;
    nextSel = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (slotIdx == IDX_W'(i)) begin
        digit      = bcdWord[i*4 +: 4];
        nextSel[i] = 1'b1;
      end
    end
  end

  // ripple flag: cleared at top digit, forced at bottom digit
  always_comb begin
    if (strobes.lastSlot)       chainIn = 1'b1;
    else if (strobes.firstSlot) chainIn = 1'b0;
    else                        chainIn = rippleFf;
    decEn  = enable & ~lampTest;
    decRbi = lampTest ? 1'b0 : (enable ? chainIn : 1'b1);
  end

  seg_decode dec_i (
    .en   (decEn),
    .rbi  (decRbi),
    .code (digit),
    .seg  (decSeg),
    .rbo  (decRbo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      segReg   <= SEG_OFF;
      selReg   <= '0;
      rboReg   <= 1'b0;
      rippleFf <= 1'b0;
    end else if (strobes.load) begin
      segReg   <= decSeg;
      selReg   <= nextSel;
      rboReg   <= decRbo;
      rippleFf <= decRbo;
    end
  end

  assign segOut   = segReg;
  assign digitSel = selReg;
  assign rboOut   = rboReg;

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(selReg));

  // R2
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(segReg) && $stable(selReg));

  // R8
  lamp_test_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load && lampTest |=> segReg == SEG_ALL && !rboReg);

  // R9
  disable_blank_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load && !enable && !lampTest |=> segReg == SEG_OFF && rboReg);

  // R4
  bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load && enable && !lampTest && digit > 4'd9
    |=> segReg == SEG_OFF && rboReg);

  // R5
  lead_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load && strobes.firstSlot && !strobes.lastSlot && enable
    && !lampTest && digit == 4'd0 |=> segReg == SEG_OFF && !rboReg);

  // R7
  last_zero_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load && strobes.lastSlot && enable && !lampTest && digit == 4'd0
    |=> segReg == SEG_ZERO && rboReg);

endmodule

// File: rtl/bcd_scan_display.sv
module bcd_scan_display
  import scan_pkg::*;
#(
  parameter int NUM_DIGITS   = 6,
  parameter int DWELL_CYCLES = 50000,
  localparam int IDX_W  = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
  localparam int WORD_W = 4 * NUM_DIGITS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WORD_W-1:0]     bcdWord,
  input  logic                  enable,
  input  logic                  lampTest,
  output logic [6:0]            segOut,
  output logic [NUM_DIGITS-1:0] digitSel,
  output logic                  rboOut
);

  logic [IDX_W-1:0] slotIdx;
  slot_strobe_t     strobes;

  scan_ctrl #(
    .NUM_DIGITS   (NUM_DIGITS),
    .DWELL_CYCLES (DWELL_CYCLES)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .slotIdx (slotIdx),
    .strobes (strobes)
  );

  scan_datapath #(
    .NUM_DIGITS (NUM_DIGITS)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .bcdWord  (bcdWord),
    .enable   (enable),
    .lampTest (lampTest),
    .slotIdx  (slotIdx),
    .strobes  (strobes),
    .segOut   (segOut),
    .digitSel (digitSel),
    .rboOut   (rboOut)
  );

endmodule

// File: tb/bcd_scan_display_tb_top.sv
module bcd_scan_display_tb_top;

  localparam int ND    = 4;
  localparam int DWELL = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4*ND-1:0] bcdWord = '0;
  logic          enable = 1'b1;
  logic          lampTest = 1'b0;
  logic [6:0]    segOut;
  logic [ND-1:0] digitSel;
  logic          rboOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  bcd_scan_display #(.NUM_DIGITS(ND), .DWELL_CYCLES(DWELL)) dut_i (
    .clk(clk), .rst(rst), .bcdWord(bcdWord), .enable(enable),
    .lampTest(lampTest), .segOut(segOut), .digitSel(digitSel), .rboOut(rboOut)
  );

  // font from R3
  localparam logic [6:0] FONT [0:9] = '{
    7'b1111110, 7'b0110000, 7'b1101101, 7'b1111001, 7'b0110011,
    7'b1011011, 7'b0011111, 7'b1110000, 7'b1111111, 7'b1110011 };

  // {lampTest, enable, bcdWord}
  localparam logic [17:0] VEC [0:11] = '{
    {2'b01, 16'h0000},  // R7 single zero
    {2'b01, 16'h1234},  // R3
    {2'b01, 16'h0507},  // R5 R6
    {2'b01, 16'h0089},  // R3 R5
    {2'b01, 16'h6000},  // R6 trailing zeros
    {2'b01, 16'h0A00},  // R4 then zeros shown
    {2'b00, 16'h9876},  // R9
    {2'b11, 16'h0012},  // R8
    {2'b01, 16'hFFFF},  // R4
    {2'b01, 16'h0100},  // R5 R6
    {2'b10, 16'h0000},  // R8 with enable low
    {2'b01, 16'h0003}   // R5 after lamp test
  };

  task automatic checkOut(input string tag, input logic [6:0] eSeg,
                          input logic [ND-1:0] eSel, input logic eRbo);
    checks++;
    if (segOut !== eSeg || digitSel !== eSel || rboOut !== eRbo) begin
      errors++;
      $display("FAIL %s: got seg=%b sel=%b rbo=%b, expected seg=%b sel=%b rbo=%b",
               tag, segOut, digitSel, rboOut, eSeg, eSel, eRbo);
    end
  endtask

  // start at a negedge whose next posedge is a slot boundary
  task automatic runFrame(input logic [15:0] word, input logic en, input logic lt);
    logic chain;
    chain = 1'b0;
    bcdWord = word; enable = en; lampTest = lt;
    for (int i = ND - 1; i >= 0; i--) begin
      logic [3:0] code;
      logic       rbi;
      logic [6:0] eSeg;
      logic       eRbo;
      string      tag;
      code = word[i*4 +: 4];
      rbi  = (i == 0) ? 1'b1 : chain;
      if (lt) begin
        eSeg = 7'h7F; eRbo = 1'b0; tag = "R8";
      end else if (!en) begin
        eSeg = 7'h00; eRbo = 1'b1; tag = "R9";
      end else if (code > 4'd9) begin
        eSeg = 7'h00; eRbo = 1'b1; tag = "R4";
      end else if (code == 4'd0) begin
        eSeg = rbi ? FONT[0] : 7'h00; eRbo = rbi;
        tag = (i == 0) ? "R7" : (rbi ? "R6" : "R5");
      end else begin
        eSeg = FONT[code]; eRbo = 1'b1; tag = "R3";
      end
      chain = eRbo;
      @(posedge clk); @(negedge clk);
      checkOut(tag, eSeg, ND'(1) << i, eRbo);
      repeat (DWELL - 1) @(posedge clk);
      @(negedge clk);
      checkOut("R2 hold", eSeg, ND'(1) << i, eRbo);
    end
  endtask

  task automatic resetAndAlign();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkOut("R1 in reset", 7'h00, '0, 1'b0);
    rst = 1'b0;
    repeat (DWELL - 1) @(posedge clk);
    @(negedge clk);
    checkOut("R1 before first slot", 7'h00, '0, 1'b0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog: got cycles=%0d, expected fewer than 20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : stim
    @(negedge clk);
    resetAndAlign();
    for (int v = 0; v < 12; v++)
      runFrame(VEC[v][15:0], VEC[v][16], VEC[v][17]);
    // R1 reset mid-scan: run part of a frame, then restart at the top digit
    bcdWord = 16'h4321; enable = 1'b1; lampTest = 1'b0;
    repeat (DWELL + 1) @(posedge clk);
    @(negedge clk);
    resetAndAlign();
    runFrame(16'h4321, 1'b1, 1'b0);
    // R2 wrap: second identical frame follows directly
    runFrame(16'h0090, 1'b1, 1'b0);
    runFrame(16'h0090, 1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule